// File: doc/BRIEF.md
# Oscillator Status and RAM Write-Protect Registers

This block is the register slice of a real-time clock that holds two 8-bit registers on a simple address/data bus. A control register carries a user-RAM write-protect bit and a free identification bit. A status register carries an oscillator-disable bit, a stop-flag suppress bit, a glitch-filter enable bit and a sticky oscillator stop flag. The slice also owns a 31-byte user RAM and refuses writes to it while write protection is on.

The oscillator's output arrives on `osc_edge_i`. It passes through a two-flop synchronizer and then feeds a rising-edge detector. If no synchronized rising edge arrives within `STOP_TIMEOUT` system clock cycles, the oscillator is treated as stopped. It is treated as running again at the next edge. Setting the oscillator-disable bit stops the oscillator at once.

The stop flag is set when the oscillator passes from running to stopped. Software clears it by writing 0 to it. The flag powers up at 1. The oscillator-disable bit and the filter-enable bit are driven out as control pins for the analog part of the clock.

Top module: `rtc_osc_status_regs`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x04 (stop flag set), `osc_enable_o` is 1 and `filter_enable_o` is 0.
- R2: The control register sits at address 0x0F. Bit 7 (write protect) and bit 0 (identification) store the written value, and bits 6..1 always read 0.
- R3: The status register sits at address 0x17. Bit 7 (oscillator disable), bit 6 (stop-flag suppress) and bit 5 (filter enable) store the written value. Bit 2 is the stop flag, and bits 4, 3, 1 and 0 always read 0. Unmapped addresses read 0.
- R4: `osc_enable_o` is the inverse of status bit 7 and `filter_enable_o` equals status bit 5.
- R5: The user RAM occupies addresses 0x20..0x3E (31 bytes). While control bit 7 is 1, writes to it are ignored. While control bit 7 is 0, writes are stored. Reads of the RAM are never blocked.
- R6: The stop flag is set when the oscillator changes from running to stopped. Stopped means no synchronized rising edge for `STOP_TIMEOUT` cycles. A steady stopped level does not set the flag again after it has been cleared.
- R7: Writing 0 to status bit 2 clears the stop flag. Writing 1 to it leaves the flag unchanged.
- R8: Setting status bit 7 while the oscillator is running stops the oscillator and sets the stop flag, unless the suppress bit is 1.
- R9: While status bit 6 is 1, the stop flag reads 0 whatever the oscillator does, and setting bit 6 clears a flag that was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| bus_addr | input | 6 | Register / RAM address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| osc_edge_i | input | 1 | Raw oscillator output, asynchronous |
| osc_enable_o | output | 1 | Oscillator run enable |
| filter_enable_o | output | 1 | Glitch filter enable |

## Verification
The stop flag is exercised with a running oscillator, with a stalled input held past the timeout, with a stall that lasts on after a clear, and with a stop forced by the disable bit. Together these separate edge-triggered setting from level-triggered setting and separate detection of a lost input from detection of a commanded stop. The same stall is repeated with the suppress bit set, which shows whether suppression masks the flag or only the detection. A seeded random mix of control, status and RAM writes is then run against a bench model, with write protect toggling, so that refused RAM writes are told apart from accepted ones and stored status bits are told apart from reserved bits.

// File: rtl/rtc_osc_pkg.sv
package rtc_osc_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h0F;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h17;
    localparam logic [ADDR_W-1:0] RAM_BASE  = 6'h20;

    // Bit positions that software decodes
    localparam int B_WP    = 7;
    localparam int B_ID    = 0;
    localparam int B_OSCOFF = 7;
    localparam int B_SUPP  = 6;
    localparam int B_FILT  = 5;
    localparam int B_STOPF = 2;

    typedef struct packed {
        logic wprot;
        logic ident;
    } ctrl_t;

    typedef struct packed {
        logic osc_off;
        logic supp;
        logic filt;
        logic stopf;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_WP] = c.wprot;
        v[B_ID] = c.ident;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_OSCOFF] = s.osc_off;
        v[B_SUPP]   = s.supp;
        v[B_FILT]   = s.filt;
        v[B_STOPF]  = s.stopf;
        return v;
    endfunction

endpackage

// File: rtl/osc_stop_monitor.sv
module osc_stop_monitor #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_raw,
    input  logic enable,
    output logic running_o,
    output logic stop_evt_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic [CW-1:0] gap_q;
    logic          expired;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], osc_raw};
    end

    assign rise    = sync_q[1] & ~sync_q[2];
    assign expired = !rise && (gap_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable || rise) gap_q <= '0;
        else if (gap_q != LAST)     gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) running_o <= 1'b0;
        else if (rise)      running_o <= 1'b1;
        else if (expired)   running_o <= 1'b0;
    end

    assign stop_evt_o = running_o && (!enable || expired);

    // R8: a disabled oscillator is never seen as running
    a_r8_disable_stops: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !running_o);

    // R6: a running oscillator only stops through a stop event
    a_r6_stop_needs_event: assert property (@(posedge clk) disable iff (rst)
        $fell(running_o) |-> $past(stop_evt_o));

endmodule

// File: rtl/wp_user_ram.sv
module wp_user_ram #(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int DEPTH = 31,
    parameter logic [AW-1:0] BASE = 6'h20
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  logic          wprot,
    output logic          hit_o,
    output logic [DW-1:0] rdata_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] off;
    logic [IW-1:0] idx;

    assign off   = addr - BASE;
    assign idx   = off[IW-1:0];
    assign hit_o = (addr >= BASE) && (off < AW'(DEPTH));

    always_ff @(posedge clk) begin
        if (we && hit_o && !wprot) mem[idx] <= wdata;
    end

    assign rdata_o = hit_o ? mem[idx] : '0;

endmodule

// File: rtl/rtc_osc_status_regs.sv
module rtc_osc_status_regs
    import rtc_osc_pkg::*;
#(
    parameter int STOP_TIMEOUT = 64,
    parameter int RAM_WORDS    = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              osc_edge_i,
    output logic              osc_enable_o,
    output logic              filter_enable_o
);
    ctrl_t ctrl_q;
    stat_t stat_q;

    logic wr_ctrl, wr_stat;
    logic supp_nx;
    logic osc_running, stop_evt;
    logic ram_hit;
    logic [DATA_W-1:0] ram_rdata;

    assign wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);
    assign wr_stat = bus_we && (bus_addr == STAT_ADDR);
    assign supp_nx = wr_stat ? bus_wdata[B_SUPP] : stat_q.supp;

    osc_stop_monitor #(.TIMEOUT(STOP_TIMEOUT)) u_mon (
        .clk        (clk),
        .rst        (rst),
        .osc_raw    (osc_edge_i),
        .enable     (!stat_q.osc_off),
        .running_o  (osc_running),
        .stop_evt_o (stop_evt)
    );

    wp_user_ram #(
        .AW(ADDR_W), .DW(DATA_W), .DEPTH(RAM_WORDS), .BASE(RAM_BASE)
    ) u_ram (
        .clk     (clk),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .wprot   (ctrl_q.wprot),
        .hit_o   (ram_hit),
        .rdata_o (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.wprot <= bus_wdata[B_WP];
            ctrl_q.ident <= bus_wdata[B_ID];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{osc_off: 1'b0, supp: 1'b0, filt: 1'b0, stopf: 1'b1};
        end else begin
            if (wr_stat) begin
                stat_q.osc_off <= bus_wdata[B_OSCOFF];
                stat_q.supp    <= bus_wdata[B_SUPP];
                stat_q.filt    <= bus_wdata[B_FILT];
            end
            if (supp_nx)                              stat_q.stopf <= 1'b0;
            else if (stop_evt)                        stat_q.stopf <= 1'b1;
            else if (wr_stat && !bus_wdata[B_STOPF])  stat_q.stopf <= 1'b0;
        end
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR)      bus_rdata = pack_ctrl(ctrl_q);
        else if (bus_addr == STAT_ADDR) bus_rdata = pack_stat(stat_q);
        else if (ram_hit)               bus_rdata = ram_rdata;
        else                            bus_rdata = '0;
    end

    assign osc_enable_o    = !stat_q.osc_off;
    assign filter_enable_o = stat_q.filt;

    // R9: suppress bit keeps the stop flag low
    a_r9_supp_holds_flag_low: assert property (@(posedge clk) disable iff (rst)
        stat_q.supp |-> !stat_q.stopf);

    // R6: the flag rises only after a running-to-stopped transition
    a_r6_flag_rise_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.stopf) |-> $past(stop_evt));

    // R7: the flag falls only on a clearing write or suppression
    a_r7_flag_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q.stopf) |->
            ($past(bus_we && bus_addr == STAT_ADDR && !bus_wdata[B_STOPF]) || stat_q.supp));

    // R8: a commanded stop of a running oscillator raises the flag
    a_r8_cmd_stop_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (osc_running && stat_q.osc_off && !supp_nx) |=> stat_q.stopf);

endmodule

// File: tb/rtc_osc_status_regs_tb.sv
module rtc_osc_status_regs_tb_top;
    localparam logic [5:0] A_CTRL = 6'h0F;
    localparam logic [5:0] A_STAT = 6'h17;
    localparam int RAM_LO = 32;
    localparam int RAM_N  = 31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       osc_edge_i = 1'b0;
    logic       osc_enable_o, filter_enable_o;
    logic       osc_run = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model
    bit m_wp, m_id, m_off, m_supp, m_filt, m_flag;
    logic [7:0] m_ram [RAM_N];

    rtc_osc_status_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .osc_edge_i(osc_edge_i),
        .osc_enable_o(osc_enable_o), .filter_enable_o(filter_enable_o)
    );

    always #5 clk = ~clk;
    always #40 if (osc_run) osc_edge_i = ~osc_edge_i;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_ctrl();
        return {m_wp, 6'b0, m_id};
    endfunction

    function automatic logic [7:0] exp_stat();
        return {m_off, m_supp, m_filt, 2'b00, m_flag, 2'b00};
    endfunction

    function automatic logic [7:0] exp_read(logic [5:0] a);
        if (a == A_CTRL) return exp_ctrl();
        if (a == A_STAT) return exp_stat();
        if (int'(a) >= RAM_LO && int'(a) < RAM_LO + RAM_N) return m_ram[int'(a) - RAM_LO];
        return 8'h00;
    endfunction

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_1234));
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl reset", v, 8'h00);
        rd(A_STAT, v); check("R1 stat reset", v, 8'h04);
        check("R1 osc_enable reset", {7'b0, osc_enable_o}, 8'h01);
        check("R1 filter_enable reset", {7'b0, filter_enable_o}, 8'h00);

        // R7 clear and write-one behaviour
        osc_run = 1'b1; idle(40);
        wr(A_STAT, 8'h00); rd(A_STAT, v); check("R7 clear by 0", v, 8'h00);
        wr(A_STAT, 8'h04); rd(A_STAT, v); check("R7 write 1 keeps 0", v, 8'h00);

        // R6 loss of edges sets flag
        osc_run = 1'b0; idle(100);
        rd(A_STAT, v); check("R6 stall sets flag", v, 8'h04);
        wr(A_STAT, 8'h04); rd(A_STAT, v); check("R7 write 1 keeps 1", v, 8'h04);
        wr(A_STAT, 8'h00); idle(100);
        rd(A_STAT, v); check("R6 steady stop no re-set", v, 8'h00);

        // R6 restart then second stall sets again
        osc_run = 1'b1; idle(40);
        rd(A_STAT, v); check("R6 restart no flag", v, 8'h00);
        osc_run = 1'b0; idle(100);
        rd(A_STAT, v); check("R6 second stall sets", v, 8'h04);

        // R9 suppress clears a set flag and masks stalls
        wr(A_STAT, 8'h44); rd(A_STAT, v); check("R9 supp clears flag", v, 8'h40);
        osc_run = 1'b1; idle(40);
        osc_run = 1'b0; idle(100);
        rd(A_STAT, v); check("R9 stall masked", v, 8'h40);
        osc_run = 1'b1; idle(40);
        wr(A_STAT, 8'hC0); idle(10);
        rd(A_STAT, v); check("R9 cmd stop masked", v, 8'hC0);
        wr(A_STAT, 8'h00); idle(40);
        rd(A_STAT, v); check("R9 after supp off", v, 8'h00);

        // R8 commanded stop, R4 outputs
        wr(A_STAT, 8'h80);
        check("R4 osc_enable low", {7'b0, osc_enable_o}, 8'h00);
        idle(5);
        rd(A_STAT, v); check("R8 cmd stop sets flag", v, 8'h84);
        wr(A_STAT, 8'h20); idle(40);
        check("R4 filter_enable high", {7'b0, filter_enable_o}, 8'h01);
        check("R4 osc_enable high", {7'b0, osc_enable_o}, 8'h01);
        rd(A_STAT, v); check("R3 filt bit stored", v, 8'h20);
        wr(A_STAT, 8'h1B); rd(A_STAT, v); check("R3 reserved bits read 0", v, 8'h00);

        // R2 control register
        wr(A_CTRL, 8'hFF); rd(A_CTRL, v); check("R2 ctrl all ones", v, 8'h81);
        wr(A_CTRL, 8'h7E); rd(A_CTRL, v); check("R2 ctrl reserved", v, 8'h00);
        wr(A_CTRL, 8'h01); rd(A_CTRL, v); check("R2 id bit", v, 8'h01);
        rd(6'h3F, v); check("R3 unmapped reads 0", v, 8'h00);

        // R5 write protect
        wr(A_CTRL, 8'h00);
        wr(6'h20, 8'h5A); wr(6'h3E, 8'hA5);
        rd(6'h20, v); check("R5 first byte", v, 8'h5A);
        rd(6'h3E, v); check("R5 last byte", v, 8'hA5);
        wr(A_CTRL, 8'h80);
        wr(6'h20, 8'h11); wr(6'h3E, 8'h22);
        rd(6'h20, v); check("R5 protected first", v, 8'h5A);
        rd(6'h3E, v); check("R5 protected last", v, 8'hA5);
        wr(A_CTRL, 8'h00);
        wr(6'h20, 8'h33); rd(6'h20, v); check("R5 unprotected", v, 8'h33);

        // random phase: oscillator running, disable bit kept 0
        m_wp = 0; m_id = 0; m_off = 0; m_supp = 0; m_filt = 0; m_flag = 0;
        wr(A_CTRL, 8'h00); wr(A_STAT, 8'h00);
        for (int i = 0; i < RAM_N; i++) begin
            m_ram[i] = 8'($urandom);
            wr(6'(RAM_LO + i), m_ram[i]);
        end
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            logic [5:0] a;
            op = int'($urandom % 4);
            d  = 8'($urandom);
            case (op)
                0: begin
                    wr(A_CTRL, d);
                    m_wp = d[7]; m_id = d[0];
                end
                1: begin
                    d[7] = 1'b0;
                    wr(A_STAT, d);
                    m_supp = d[6]; m_filt = d[5];
                    if (m_supp || !d[2]) m_flag = 0;
                end
                2: begin
                    a = 6'(RAM_LO + int'($urandom % RAM_N));
                    wr(a, d);
                    if (!m_wp) m_ram[int'(a) - RAM_LO] = d;
                end
                default: begin
                    a = 6'($urandom);
                    rd(a, v);
                    check("R5 R2 R3 random read", v, exp_read(a));
                end
            endcase
            check("R4 random filter out", {7'b0, filter_enable_o}, {7'b0, m_filt});
        end
        for (int i = 0; i < RAM_N; i++) begin
            rd(6'(RAM_LO + i), v);
            check("R5 final ram sweep", v, m_ram[i]);
        end
        rd(A_STAT, v); check("R7 final stat", v, exp_stat());

        done = 1'b1;
        summary();
        $finish;
    end
endmodule